// File: doc/BRIEF.md
# Bidirectional Saturating Shifter

This block is a registered shift unit for a processor datapath. It works on a 64-bit operand or on the low 32 bits of it. The shift count is a 7-bit two's-complement value. For the bidirectional operations the sign of that count picks the direction: a negative count on a left-type operation shifts right by the magnitude, and a negative count on a right-type operation shifts left. A reverse shift is built as a shift by (magnitude - 1) followed by a shift by one. This lets a count of -64 clear every bit of a 64-bit operand, or fill it with sign bits, without ever asking for a shift as wide as the operand.

The unit also provides two other groups of operations. The first is a pair of plain shifts that read the count as unsigned and give zero once the count reaches the operand width. The second is a pair of rotates. Two saturating operations work on 32-bit signed data. When a left shift would move the value outside the signed 32-bit range, they clamp it to the nearest limit and raise an overflow flag. The result and the flag are registered together, so both appear one clock after the inputs are sampled.

Top module: `bsh_shifter`

## Requirements
- R1: While `rst_ni` is low, `result_o` is zero and `ovf_o` is low, whatever the inputs are.
- R2: The result and the overflow flag for the inputs sampled at one rising clock edge appear after that edge and hold until the next rising edge.
- R3: Operation codes 0 (arithmetic) and 1 (logical) are left-type bidirectional shifts. A count of zero or more shifts left by the count. A negative count shifts right by its magnitude, with sign fill for code 0 and zero fill for code 1. A magnitude equal to or above the operand width gives all zeros (logical), or all copies of the sign bit (arithmetic right).
- R4: Operation codes 2 (arithmetic) and 3 (logical) are right-type bidirectional shifts. A count of zero or more shifts right by the count, with sign fill for code 2 and zero fill for code 3. A negative count shifts left by its magnitude, up to 64 places.
- R5: With `wide_i` high, operations use all 64 bits of `src_i`. With `wide_i` low, they use only `src_i[31:0]`, and `result_o[63:32]` is zero. The saturating codes 4 and 5 always work this narrow way, whatever `wide_i` is.
- R6: Code 4 (saturating left) works on the signed 32-bit value `src_i[31:0]`. With a count of zero or more, the result is that value times 2^count, clamped to the range [-2^31, 2^31-1]. With a negative count, the result is the value shifted right arithmetically by the count's magnitude.
- R7: Code 5 (saturating right) works on the signed 32-bit value `src_i[31:0]`. With a count of zero or more, it shifts right arithmetically. With a negative count, it gives the value times 2^magnitude, clamped to [-2^31, 2^31-1], for magnitudes up to 64.
- R8: `ovf_o` is high exactly when a code 4 or code 5 result was clamped. It is low for every other operation.
- R9: Codes 6 (plain logical right) and 7 (plain left) read `amt_i` as an unsigned number from 0 to 127. Any count equal to or above the operand width (32 or 64) gives zero.
- R10: Codes 8 (rotate left) and 9 (rotate right) rotate by `amt_i` modulo the operand width, using the low 5 or 6 bits of the count. A rotate amount of zero returns the operand unchanged.
- R11: Codes 10 to 15 give a zero result with `ovf_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; inputs are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Source operand |
| amt_i | input | 7 | Shift or rotate count, two's complement for the bidirectional and saturating codes |
| op_i | input | 4 | Operation code, 0 to 9 as listed in the requirements |
| wide_i | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit operation |
| result_o | output | 64 | Registered result |
| ovf_o | output | 1 | Registered flag, high when a saturating result was clamped |

## Verification
The bound assertions check the properties that hold on every cycle:
- the overflow flag never rises outside the two saturating codes;
- the upper half of the result is cleared in narrow mode;
- a rotate by zero returns the operand unchanged;
- an out-of-range plain shift gives zero;
- a clamped saturating result lands on the limit that matches the operand's sign;
- unused codes give a zero result.

Only the bench's sweep can show that each operation gives the exact arithmetic value. It covers every count from -64 to 63, in both widths, on operands chosen to sit at sign and magnitude edges. That includes the -64 reverse shift and the shifts where bits are lost past 64 places and then tested for saturation. The bench alone also checks the behaviour while reset is held and the one-cycle latency.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

    typedef enum logic [3:0] {
        OP_BI_ASL  = 4'd0,
        OP_BI_LSL  = 4'd1,
        OP_BI_ASR  = 4'd2,
        OP_BI_LSR  = 4'd3,
        OP_SAT_ASL = 4'd4,
        OP_SAT_ASR = 4'd5,
        OP_PL_LSR  = 4'd6,
        OP_PL_ASL  = 4'd7,
        OP_ROL     = 4'd8,
        OP_ROR     = 4'd9
    } bsh_op_e;

    // Saturating codes: 32-bit signed, width select ignored.
    function automatic logic op_is_sat(input logic [3:0] op);
        return (op == OP_SAT_ASL) || (op == OP_SAT_ASR);
    endfunction

    // Source is treated as signed (sign fill on right shifts).
    function automatic logic op_is_arith(input logic [3:0] op);
        return (op == OP_BI_ASL) || (op == OP_BI_ASR) || op_is_sat(op);
    endfunction

    // A non-negative count moves bits towards the MSB.
    function automatic logic op_is_left_type(input logic [3:0] op);
        return (op == OP_BI_ASL) || (op == OP_BI_LSL) || (op == OP_SAT_ASL);
    endfunction

endpackage

// File: rtl/bsh_bidir.sv
// Bidirectional shift on a container already extended by the caller.
// A negative count reverses direction; the reverse step is split into
// (|amt| - 1) followed by one, so magnitude 2^(AMT_W-1) needs no wider shifter.
module bsh_bidir #(
    parameter int W     = 64,
    parameter int AMT_W = 7
) (
    input  logic [W-1:0]     opnd_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             left_type_i,
    input  logic             arith_i,
    output logic [W-1:0]     res_o
);
    localparam int MAG_W = AMT_W - 1;

    function automatic logic [W-1:0] shr(
        input logic [W-1:0]     v,
        input logic [MAG_W-1:0] n,
        input logic             ar
    );
        logic signed [W-1:0] t;
        t = $signed(v) >>> n;
        return ar ? t : (v >> n);
    endfunction

    logic             neg;
    logic [MAG_W-1:0] fwd;
    logic [MAG_W-1:0] rev_k;
    logic [W-1:0]     rev_first;

    always_comb begin
        neg       = amt_i[AMT_W-1];
        fwd       = amt_i[MAG_W-1:0];
        rev_k     = ~amt_i[MAG_W-1:0];   // -amt - 1 for negative counts
        rev_first = '0;
        if (!neg) begin
            res_o = left_type_i ? (opnd_i << fwd) : shr(opnd_i, fwd, arith_i);
        end else if (left_type_i) begin
            rev_first = shr(opnd_i, rev_k, arith_i);
            res_o     = shr(rev_first, MAG_W'(1), arith_i);
        end else begin
            rev_first = opnd_i << rev_k;
            res_o     = rev_first << 1;
        end
    end

endmodule

// File: rtl/bsh_satl.sv
// Saturating left shift of a W-bit signed value in a CW-bit container.
// Total shift = k_i + extra_i. Clamping compares the container result
// against the original operand's sign.
module bsh_satl #(
    parameter int W   = 32,
    parameter int CW  = 64,
    parameter int K_W = 6
) (
    input  logic [W-1:0]   src_i,
    input  logic [K_W-1:0] k_i,
    input  logic           extra_i,
    output logic [W-1:0]   res_o,
    output logic           ovf_o
);
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic [CW-1:0] ext;
    logic [CW-1:0] shifted;
    logic [CW-W:0] top_bits;
    logic          fits;
    logic [W-1:0]  sat1;
    logic          positive;

    always_comb begin
        ext      = {{(CW-W){src_i[W-1]}}, src_i};
        shifted  = (ext << k_i) << extra_i;
        top_bits = shifted[CW-1:W-1];
        fits     = (&top_bits) | (~|top_bits);
        sat1     = fits ? shifted[W-1:0] : (shifted[CW-1] ? MINV : MAXV);
        positive = !src_i[W-1] && (|src_i);
        if (sat1[W-1] != src_i[W-1]) begin
            res_o = src_i[W-1] ? MINV : MAXV;
            ovf_o = 1'b1;
        end else if (positive && (shifted == '0)) begin
            res_o = MAXV;
            ovf_o = 1'b1;
        end else begin
            res_o = sat1;
            ovf_o = !fits;
        end
    end

endmodule

// File: rtl/bsh_rot.sv
// Rotate of a W-bit operand by k_i places, left or right.
module bsh_rot #(
    parameter int W   = 32,
    parameter int K_W = $clog2(W)
) (
    input  logic [W-1:0]   x_i,
    input  logic [K_W-1:0] k_i,
    input  logic           left_i,
    output logic [W-1:0]   res_o
);
    logic [2*W-1:0] dbl;
    logic [2*W-1:0] lsh;
    logic [2*W-1:0] rsh;

    always_comb begin
        dbl   = {x_i, x_i};
        lsh   = dbl << k_i;
        rsh   = dbl >> k_i;
        res_o = left_i ? lsh[2*W-1:W] : rsh[W-1:0];
    end

endmodule

// File: rtl/bsh_shifter.sv
module bsh_shifter
    import bsh_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int AMT_W  = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] src_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic [3:0]        op_i,
    input  logic              wide_i,
    output logic [DATA_W-1:0] result_o,
    output logic              ovf_o
);
    localparam int NARROW_W = DATA_W / 2;
    localparam int NK_W     = $clog2(NARROW_W);
    localparam int WK_W     = $clog2(DATA_W);
    localparam int MAG_W    = AMT_W - 1;
    localparam int UPPER_W  = DATA_W - NARROW_W;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              ovf;
    } out_t;

    out_t out_d, out_q;

    logic                narrow_eff;
    logic                arith;
    logic                left_type;
    logic                neg;
    logic [DATA_W-1:0]   opnd;
    logic [DATA_W-1:0]   plain_src;
    logic [DATA_W-1:0]   bidir_res;
    logic [MAG_W-1:0]    sat_k;
    logic                sat_extra;
    logic [NARROW_W-1:0] sat_res;
    logic                sat_ovf;
    logic [NARROW_W-1:0] rot_n_res;
    logic [DATA_W-1:0]   rot_w_res;
    logic                rot_left;
    logic                plain_over;

    // Operand preparation: narrow values are sign- or zero-extended into the container.
    always_comb begin
        narrow_eff = !wide_i || op_is_sat(op_i);
        arith      = op_is_arith(op_i);
        left_type  = op_is_left_type(op_i);
        neg        = amt_i[AMT_W-1];
        plain_src  = wide_i ? src_i : {{UPPER_W{1'b0}}, src_i[NARROW_W-1:0]};
        if (!narrow_eff) begin
            opnd = src_i;
        end else if (arith) begin
            opnd = {{UPPER_W{src_i[NARROW_W-1]}}, src_i[NARROW_W-1:0]};
        end else begin
            opnd = {{UPPER_W{1'b0}}, src_i[NARROW_W-1:0]};
        end
        sat_k      = (op_i == OP_SAT_ASL) ? amt_i[MAG_W-1:0] : ~amt_i[MAG_W-1:0];
        sat_extra  = (op_i == OP_SAT_ASR);
        rot_left   = (op_i == OP_ROL);
        plain_over = int'(amt_i) >= (wide_i ? DATA_W : NARROW_W);
    end

    bsh_bidir #(
        .W     (DATA_W),
        .AMT_W (AMT_W)
    ) i_bidir (
        .opnd_i      (opnd),
        .amt_i       (amt_i),
        .left_type_i (left_type),
        .arith_i     (arith),
        .res_o       (bidir_res)
    );

    bsh_satl #(
        .W   (NARROW_W),
        .CW  (DATA_W),
        .K_W (MAG_W)
    ) i_satl (
        .src_i   (src_i[NARROW_W-1:0]),
        .k_i     (sat_k),
        .extra_i (sat_extra),
        .res_o   (sat_res),
        .ovf_o   (sat_ovf)
    );

    bsh_rot #(
        .W   (NARROW_W),
        .K_W (NK_W)
    ) i_rot_narrow (
        .x_i    (src_i[NARROW_W-1:0]),
        .k_i    (amt_i[NK_W-1:0]),
        .left_i (rot_left),
        .res_o  (rot_n_res)
    );

    bsh_rot #(
        .W   (DATA_W),
        .K_W (WK_W)
    ) i_rot_wide (
        .x_i    (src_i),
        .k_i    (amt_i[WK_W-1:0]),
        .left_i (rot_left),
        .res_o  (rot_w_res)
    );

    // Next-state selection.
    always_comb begin
        out_d = '0;
        case (op_i)
            OP_BI_ASL, OP_BI_LSL, OP_BI_ASR, OP_BI_LSR: begin
                out_d.res = bidir_res;
            end
            OP_SAT_ASL: begin
                if (!neg) begin
                    out_d.res = {{UPPER_W{1'b0}}, sat_res};
                    out_d.ovf = sat_ovf;
                end else begin
                    out_d.res = bidir_res;
                end
            end
            OP_SAT_ASR: begin
                if (neg) begin
                    out_d.res = {{UPPER_W{1'b0}}, sat_res};
                    out_d.ovf = sat_ovf;
                end else begin
                    out_d.res = bidir_res;
                end
            end
            OP_PL_LSR: begin
                out_d.res = plain_over ? '0 : (plain_src >> amt_i);
            end
            OP_PL_ASL: begin
                out_d.res = plain_over ? '0 : (plain_src << amt_i);
            end
            OP_ROL, OP_ROR: begin
                out_d.res = wide_i ? rot_w_res : {{UPPER_W{1'b0}}, rot_n_res};
            end
            default: begin
                out_d = '0;
            end
        endcase
        if (narrow_eff) begin
            out_d.res[DATA_W-1:NARROW_W] = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign result_o = out_q.res;
    assign ovf_o    = out_q.ovf;

endmodule

// File: rtl/bsh_shifter_chk.sv
module bsh_shifter_chk
    import bsh_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int AMT_W  = 7
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [DATA_W-1:0] src_i,
    input logic [AMT_W-1:0]  amt_i,
    input logic [3:0]        op_i,
    input logic              wide_i,
    input logic [DATA_W-1:0] result_o,
    input logic              ovf_o
);
    localparam int NARROW_W = DATA_W / 2;
    localparam int UPPER_W  = DATA_W - NARROW_W;
    localparam logic [DATA_W-1:0] POS_LIM = {{(UPPER_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] NEG_LIM = {{UPPER_W{1'b0}}, 1'b1, {(NARROW_W-1){1'b0}}};

    // R8: the flag stays low for non-saturating codes
    assert_ovf_only_sat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !op_is_sat(op_i) |=> !ovf_o);

    // R5: narrow mode clears the upper half of the result
    assert_narrow_upper_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wide_i |=> (result_o[DATA_W-1:NARROW_W] == '0));

    // R10: a rotate by zero returns the operand
    assert_rot_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((op_i == OP_ROL || op_i == OP_ROR) && amt_i == '0) |=>
        (result_o == ($past(wide_i) ? $past(src_i)
                      : {{UPPER_W{1'b0}}, $past(src_i[NARROW_W-1:0])})));

    // R9: a plain shift by the width or more gives zero
    assert_plain_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((op_i == OP_PL_LSR || op_i == OP_PL_ASL) &&
         int'(amt_i) >= (wide_i ? DATA_W : NARROW_W)) |=> (result_o == '0));

    // R6: a clamped left shift of a non-negative operand goes to the positive limit
    assert_pos_sat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_SAT_ASL && !amt_i[AMT_W-1] && !src_i[NARROW_W-1]) |=>
        (!ovf_o || result_o == POS_LIM));

    // R7: a clamped reverse shift of a negative operand goes to the negative limit
    assert_neg_sat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i == OP_SAT_ASR && amt_i[AMT_W-1] && src_i[NARROW_W-1]) |=>
        (!ovf_o || result_o == NEG_LIM));

    // R11: unused codes give zero
    assert_unused_code_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op_i > 4'd9) |=> (result_o == '0 && !ovf_o));

endmodule

bind bsh_shifter bsh_shifter_chk #(
    .DATA_W (DATA_W),
    .AMT_W  (AMT_W)
) i_bsh_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .amt_i    (amt_i),
    .op_i     (op_i),
    .wide_i   (wide_i),
    .result_o (result_o),
    .ovf_o    (ovf_o)
);

// File: tb/test_bsh_shifter.sv
module test_bsh_shifter;

    logic        clk;
    logic        rst_ni;
    logic [63:0] src;
    logic [6:0]  amt;
    logic [3:0]  op;
    logic        wide;
    logic [63:0] result;
    logic        ovf;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [63:0] last_exp;

    bsh_shifter #(
        .DATA_W (64),
        .AMT_W  (7)
    ) i_bsh_shifter (
        .clk_i    (clk),
        .rst_ni   (rst_ni),
        .src_i    (src),
        .amt_i    (amt),
        .op_i     (op),
        .wide_i   (wide),
        .result_o (result),
        .ovf_o    (ovf)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic logic [63:0] pick(input int i);
        case (i)
            0:       return 64'h0;
            1:       return 64'h1;
            2:       return 64'hFFFF_FFFF_FFFF_FFFF;
            3:       return 64'h8000_0000_0000_0000;
            4:       return 64'h0000_0000_8000_0000;
            5:       return 64'h0000_0000_7FFF_FFFF;
            6:       return 64'h1234_5678_9ABC_DEF0;
            7:       return 64'hFEDC_BA98_7654_3210;
            8:       return 64'h0000_0000_4000_0000;
            9:       return 64'hFFFF_FFFF_C000_0000;
            10:      return 64'h0000_0000_0000_0003;
            default: return 64'hA5A5_5A5A_F00F_0FF0;
        endcase
    endfunction

    function automatic string tag(input int o);
        case (o)
            0, 1:    return "R3";
            2, 3:    return "R4";
            4:       return "R6";
            5:       return "R7";
            6, 7:    return "R9";
            8, 9:    return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic logic [63:0] lsh(input logic [63:0] x, input int m);
        return (m >= 64) ? 64'h0 : (x << m);
    endfunction

    function automatic logic [63:0] rsh(input logic [63:0] x, input int m);
        return (m >= 64) ? 64'h0 : (x >> m);
    endfunction

    function automatic logic [63:0] ash(input logic signed [63:0] x, input int m);
        logic signed [63:0] t;
        if (m >= 64) t = x[63] ? -64'sd1 : 64'sd0;
        else         t = x >>> m;
        return t;
    endfunction

    function automatic logic [63:0] ash32(input logic signed [31:0] x, input int m);
        logic signed [31:0] t;
        t = x >>> ((m > 31) ? 31 : m);
        return {32'h0, t};
    endfunction

    // Exact value times 2^n, clamped to the signed 32-bit range.
    task automatic sat_model(input logic signed [31:0] x, input int n,
                             output logic [63:0] r, output bit ov);
        logic signed [127:0] v;
        logic signed [127:0] hi;
        logic signed [127:0] lo;
        v  = {{96{x[31]}}, x};
        v  = v <<< n;
        hi = 128'sh7FFF_FFFF;
        lo = -hi - 128'sd1;
        if (v > hi) begin
            r = 64'h7FFF_FFFF; ov = 1'b1;
        end else if (v < lo) begin
            r = 64'h8000_0000; ov = 1'b1;
        end else begin
            r = {32'h0, v[31:0]}; ov = 1'b0;
        end
    endtask

    task automatic model(input logic [63:0] s, input int a, input int o, input bit w,
                         output logic [63:0] r, output bit ov);
        int wd;
        int m;
        int u;
        int k;
        logic [63:0] x;
        logic signed [63:0] xs;
        logic signed [31:0] s32;
        logic [63:0] msk;
        wd  = w ? 64 : 32;
        m   = (a < 0) ? -a : a;
        u   = a & 127;
        k   = a & (wd - 1);
        x   = w ? s : {32'h0, s[31:0]};
        xs  = w ? s : {{32{s[31]}}, s[31:0]};
        s32 = s[31:0];
        msk = w ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        ov  = 1'b0;
        r   = 64'h0;
        case (o)
            0: r = (a >= 0) ? lsh(x, a) : ash(xs, m);
            1: r = (a >= 0) ? lsh(x, a) : rsh(x, m);
            2: r = (a >= 0) ? ash(xs, a) : lsh(x, m);
            3: r = (a >= 0) ? rsh(x, a) : lsh(x, m);
            4: if (a >= 0) sat_model(s32, a, r, ov); else r = ash32(s32, m);
            5: if (a >= 0) r = ash32(s32, a); else sat_model(s32, m, r, ov);
            6: r = (u >= wd) ? 64'h0 : (x >> u);
            7: r = (u >= wd) ? 64'h0 : (x << u);
            8: r = (k == 0) ? x : (((x << k) | (x >> (wd - k))) & msk);
            9: r = (k == 0) ? x : (((x >> k) | (x << (wd - k))) & msk);
            default: r = 64'h0;
        endcase
        if (!w || o == 4 || o == 5) r[63:32] = 32'h0;
    endtask

    task automatic run_vec(input logic [63:0] s, input int a, input int o, input bit w);
        logic [63:0] er;
        bit eo;
        @(negedge clk);
        src  = s;
        amt  = a[6:0];
        op   = o[3:0];
        wide = w;
        @(negedge clk);
        model(s, a, o, w, er, eo);
        last_exp = er;
        checks++;
        if (result !== er) begin
            errors++;
            $display("FAIL %s op=%0d amt=%0d wide=%0b src=%h: actual %h expected %h",
                     tag(o), o, a, w, s, result, er);
        end
        checks++;
        if (ovf !== eo) begin
            errors++;
            $display("FAIL R8 op=%0d amt=%0d src=%h: actual ovf %0b expected %0b",
                     o, a, s, ovf, eo);
        end
        if (!w) begin
            checks++;
            if (result[63:32] !== 32'h0) begin
                errors++;
                $display("FAIL R5 op=%0d: actual upper %h expected 00000000", o, result[63:32]);
            end
        end
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: actual still running, expected finished");
            summary();
        end
    end

    initial begin
        rst_ni = 1'b0;
        src    = 64'hDEAD_BEEF_0BAD_F00D;
        amt    = 7'd3;
        op     = 4'd8;
        wide   = 1'b1;
        repeat (3) @(negedge clk);
        // R1: outputs held at zero during reset despite active inputs
        checks++;
        if (result !== 64'h0 || ovf !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: actual %h/%0b expected 0/0", result, ovf);
        end
        src = 64'h1;
        @(negedge clk);
        checks++;
        if (result !== 64'h0 || ovf !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset held: actual %h/%0b expected 0/0", result, ovf);
        end
        rst_ni = 1'b1;

        for (int w = 0; w < 2; w++) begin
            for (int o = 0; o < 16; o++) begin
                for (int si = 0; si < 12; si++) begin
                    for (int a = -64; a < 64; a++) begin
                        run_vec(pick(si), a, o, w[0]);
                    end
                end
            end
        end

        // R2: new inputs do not reach the output before the next rising edge
        @(negedge clk);
        src  = 64'h0123_4567_89AB_CDEF;
        amt  = 7'd0;
        op   = 4'd8;
        wide = 1'b1;
        #1;
        checks++;
        if (result !== last_exp) begin
            errors++;
            $display("FAIL R2 early update: actual %h expected %h", result, last_exp);
        end
        @(negedge clk);
        checks++;
        if (result !== 64'h0123_4567_89AB_CDEF) begin
            errors++;
            $display("FAIL R2 one-cycle result: actual %h expected 0123456789abcdef", result);
        end

        done = 1;
        summary();
    end

endmodule